// File: doc/BRIEF.md
# Interrupt and Exception Acceptance Arbiter

This block decides which pending event the core takes at the next instruction boundary. It watches four kinds of source. The first is a non-maskable interrupt pin. The second is a maskable interrupt pin whose vector comes from an external controller. The third is a software-interrupt request that carries its own 8-bit vector. The fourth is a bank of internally detected exception flags, one per low vector number, each tagged as fault, trap or abort.

When the core signals a boundary, the arbiter ranks everything present and picks one winner. One cycle later it reports the winner's vector, its class, whether it came from an external pin, the return pointer to save, and whether the event can be restarted. Interrupts that lose stay latched until they are taken. Exceptions and software requests that lose are dropped, because re-executing the instruction raises them again. When the maskable interrupt wins, a one-cycle acknowledge goes back to its source.

Descriptor lookup, stack pushes, instruction execution and the external interrupt controller are outside this block.

Top module: `evt_accept_arb`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `take_o`, `intr_ack_o`, `ext_o`, `restart_o`, `vec_o`, `cls_o` and `ret_pc_o` are all 0, and no interrupt is pending.
- R2: An event is taken only in a cycle with `boundary_i` high. The outputs describe that decision in the next cycle, and they are all 0 in any cycle that follows a cycle with no decision.
- R3: The winner is chosen by rank: abort flags first, then fault flags, then trap flags, then the software request, then a pending non-maskable interrupt, then a pending enabled maskable interrupt. Among flags of the same kind, the lowest index wins.
- R4: `exc_kind_i[2*i+1:2*i]` gives the kind of exception flag i: 0 means no exception, 1 means fault, 2 means trap and 3 means abort. The reported vector of flag i is i.
- R5: A rising edge on `nmi_i` makes a non-maskable interrupt pending. It is taken with vector 2 whatever the value of `if_en_i`, and it stops being pending once taken.
- R6: A high `intr_i` with no maskable interrupt pending makes one pending and captures `intr_vec_i` at that moment. It is taken only at a boundary where `if_en_i` is 1, and it stays pending while masked.
- R7: `intr_ack_o` pulses for exactly the cycle in which a taken maskable interrupt is reported. The maskable pending latch clears only at that acknowledge.
- R8: A pending interrupt that loses stays pending. An exception flag or software request that loses, or that is present outside a boundary, is discarded and never taken later.
- R9: `ret_pc_o` is `cur_pc_i` of the decision cycle for faults and aborts. It is `next_pc_i` for traps, software interrupts and both kinds of external interrupt.
- R10: `restart_o` is 0 for an abort and 1 for every other taken event.
- R11: `ext_o` is 1 exactly when the taken event came from `nmi_i` or `intr_i`.
- R12: `cls_o` encodes the class as follows: 0 none, 1 abort, 2 fault, 3 trap, 4 software, 5 non-maskable, 6 maskable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | Core is at an instruction boundary this cycle |
| if_en_i | input | 1 | Interrupt-enable flag |
| nmi_i | input | 1 | Non-maskable interrupt pin |
| intr_i | input | 1 | Maskable interrupt request |
| intr_vec_i | input | 8 | Vector supplied with the maskable request |
| swi_req_i | input | 1 | Software-interrupt instruction at this boundary |
| swi_vec_i | input | 8 | Vector of the software interrupt |
| exc_kind_i | input | 2*NEXC | Per-flag exception kind |
| cur_pc_i | input | AW | Address of the instruction that raised the exception |
| next_pc_i | input | AW | Address of the next instruction to run, which is the branch target if a branch was taken |
| take_o | output | 1 | An event was taken at the previous boundary |
| vec_o | output | 8 | Selected vector |
| cls_o | output | 3 | Selected event class |
| ext_o | output | 1 | Event came from an external pin |
| ret_pc_o | output | AW | Return pointer to save |
| restart_o | output | 1 | Event can be restarted |
| intr_ack_o | output | 1 | Acknowledge to the maskable interrupt source |

## Verification
The bench aims at collisions. It applies an abort, a fault and a trap in the same cycle as a pending interrupt; a flawed ranking would report the wrong class, or would lose the interrupt instead of serving it at the following boundary. It holds a maskable request while the enable flag is low. A design that ignores the mask would acknowledge it too early, and one that drops the latch would never take it. It also presents flags with kind 0, and exceptions outside a boundary; a design that latched or decoded these would take events that never existed. Return pointers are compared for every class, so a fault that saves the next address, or a trap that saves the current one, shows up directly.

// File: rtl/evt_arb_pkg.sv
// Shared types for the event acceptance arbiter.
// Assumes at most 256 vectors (8-bit vector field).
package evt_arb_pkg;
    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_ABORT = 3'd1,
        CLS_FAULT = 3'd2,
        CLS_TRAP  = 3'd3,
        CLS_SWI   = 3'd4,
        CLS_NMI   = 3'd5,
        CLS_INTR  = 3'd6
    } evt_cls_e;

    typedef enum logic [1:0] {
        KIND_OFF   = 2'd0,
        KIND_FAULT = 2'd1,
        KIND_TRAP  = 2'd2,
        KIND_ABORT = 2'd3
    } exc_kind_e;

    localparam logic [7:0] NMI_VECTOR = 8'd2;
endpackage

// File: rtl/evt_exc_pick.sv
// Finds the lowest-index exception flag whose kind equals KIND.
// Assumes NEXC <= 256 so that an index fits the 8-bit vector.
module evt_exc_pick #(
    parameter int          NEXC = 32,
    parameter logic [1:0]  KIND = 2'd1
) (
    input  logic [2*NEXC-1:0] kinds_i,
    output logic              hit_o,
    output logic [7:0]        idx_o
);
    // Priority scan: walking down means the lowest match is written last.
    always_comb begin
        hit_o = 1'b0;
        idx_o = 8'd0;
        for (int i = NEXC - 1; i >= 0; i--) begin
            if (kinds_i[2*i +: 2] == KIND) begin
                hit_o = 1'b1;
                idx_o = 8'(i);
            end
        end
    end
endmodule

// File: rtl/evt_pend.sv
// Pending latches for the two external interrupt pins.
// The non-maskable request is edge detected; the maskable one captures
// its vector when the latch fills and holds it until acknowledged.
module evt_pend (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nmi_i,
    input  logic       intr_i,
    input  logic [7:0] intr_vec_i,
    input  logic       nmi_take_i,
    input  logic       intr_take_i,
    output logic       nmi_pend_o,
    output logic       intr_pend_o,
    output logic [7:0] intr_vec_o
);
    logic nmi_prev_q;

    // Non-maskable: set on rising edge, clear when taken (new edge wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_o <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_i;
            nmi_pend_o <= (nmi_pend_o & ~nmi_take_i) | (nmi_i & ~nmi_prev_q);
        end
    end

    // Maskable: fill when empty, clear only on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_pend_o <= 1'b0;
            intr_vec_o  <= 8'd0;
        end else if (intr_take_i) begin
            intr_pend_o <= 1'b0;
        end else if (!intr_pend_o && intr_i) begin
            intr_pend_o <= 1'b1;
            intr_vec_o  <= intr_vec_i;
        end
    end
endmodule

// File: rtl/evt_sel.sv
// Combinational ranking of all candidate events at a boundary.
// Assumes exception candidates are already reduced to one per kind.
module evt_sel
    import evt_arb_pkg::*;
(
    input  logic       boundary_i,
    input  logic       if_en_i,
    input  logic       abort_hit_i,
    input  logic [7:0] abort_idx_i,
    input  logic       fault_hit_i,
    input  logic [7:0] fault_idx_i,
    input  logic       trap_hit_i,
    input  logic [7:0] trap_idx_i,
    input  logic       swi_req_i,
    input  logic [7:0] swi_vec_i,
    input  logic       nmi_pend_i,
    input  logic       intr_pend_i,
    input  logic [7:0] intr_vec_i,
    output logic       take_o,
    output logic [7:0] vec_o,
    output evt_cls_e   cls_o,
    output logic       use_next_o,
    output logic       nmi_take_o,
    output logic       intr_take_o
);
    // Fixed rank: abort, fault, trap, software, non-maskable, maskable.
    always_comb begin
        take_o      = 1'b0;
        vec_o       = 8'd0;
        cls_o       = CLS_NONE;
        use_next_o  = 1'b0;
        nmi_take_o  = 1'b0;
        intr_take_o = 1'b0;
        if (boundary_i) begin
            take_o = 1'b1;
            if (abort_hit_i) begin
                vec_o = abort_idx_i;  cls_o = CLS_ABORT;
            end else if (fault_hit_i) begin
                vec_o = fault_idx_i;  cls_o = CLS_FAULT;
            end else if (trap_hit_i) begin
                vec_o = trap_idx_i;   cls_o = CLS_TRAP;   use_next_o = 1'b1;
            end else if (swi_req_i) begin
                vec_o = swi_vec_i;    cls_o = CLS_SWI;    use_next_o = 1'b1;
            end else if (nmi_pend_i) begin
                vec_o = NMI_VECTOR;   cls_o = CLS_NMI;    use_next_o = 1'b1;
                nmi_take_o = 1'b1;
            end else if (intr_pend_i && if_en_i) begin
                vec_o = intr_vec_i;   cls_o = CLS_INTR;   use_next_o = 1'b1;
                intr_take_o = 1'b1;
            end else begin
                take_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/evt_accept_arb.sv
// Top of the event acceptance arbiter. Ranks exceptions, software and
// external interrupts at an instruction boundary and registers the winner.
// Assumes exception flag i stands for vector i and flags are valid only
// in the boundary cycle.
module evt_accept_arb
    import evt_arb_pkg::*;
#(
    parameter int NEXC = 32,
    parameter int AW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              if_en_i,
    input  logic              nmi_i,
    input  logic              intr_i,
    input  logic [7:0]        intr_vec_i,
    input  logic              swi_req_i,
    input  logic [7:0]        swi_vec_i,
    input  logic [2*NEXC-1:0] exc_kind_i,
    input  logic [AW-1:0]     cur_pc_i,
    input  logic [AW-1:0]     next_pc_i,
    output logic              take_o,
    output logic [7:0]        vec_o,
    output logic [2:0]        cls_o,
    output logic              ext_o,
    output logic [AW-1:0]     ret_pc_o,
    output logic              restart_o,
    output logic              intr_ack_o
);
    localparam int NKIND = 3;
    localparam logic [1:0] KSEL [NKIND] = '{KIND_ABORT, KIND_FAULT, KIND_TRAP};

    logic       hit [NKIND];
    logic [7:0] idx [NKIND];
    logic       nmi_pend, intr_pend;
    logic [7:0] intr_vec_l;
    logic       take_d, use_next_d, nmi_take_d, intr_take_d;
    logic [7:0] vec_d;
    evt_cls_e   cls_d;

    // One priority scan per exception kind.
    for (genvar k = 0; k < NKIND; k++) begin : g_pick
        evt_exc_pick #(.NEXC(NEXC), .KIND(KSEL[k])) pick_i (
            .kinds_i (exc_kind_i),
            .hit_o   (hit[k]),
            .idx_o   (idx[k])
        );
    end

    evt_pend pend_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_i       (nmi_i),
        .intr_i      (intr_i),
        .intr_vec_i  (intr_vec_i),
        .nmi_take_i  (nmi_take_d),
        .intr_take_i (intr_take_d),
        .nmi_pend_o  (nmi_pend),
        .intr_pend_o (intr_pend),
        .intr_vec_o  (intr_vec_l)
    );

    evt_sel sel_i (
        .boundary_i  (boundary_i),
        .if_en_i     (if_en_i),
        .abort_hit_i (hit[0]),
        .abort_idx_i (idx[0]),
        .fault_hit_i (hit[1]),
        .fault_idx_i (idx[1]),
        .trap_hit_i  (hit[2]),
        .trap_idx_i  (idx[2]),
        .swi_req_i   (swi_req_i),
        .swi_vec_i   (swi_vec_i),
        .nmi_pend_i  (nmi_pend),
        .intr_pend_i (intr_pend),
        .intr_vec_i  (intr_vec_l),
        .take_o      (take_d),
        .vec_o       (vec_d),
        .cls_o       (cls_d),
        .use_next_o  (use_next_d),
        .nmi_take_o  (nmi_take_d),
        .intr_take_o (intr_take_d)
    );

    // Output register: one cycle after the boundary decision.
    always_ff @(posedge clk) begin
        if (!rst_n || !take_d) begin
            take_o     <= 1'b0;
            vec_o      <= 8'd0;
            cls_o      <= CLS_NONE;
            ext_o      <= 1'b0;
            ret_pc_o   <= '0;
            restart_o  <= 1'b0;
            intr_ack_o <= 1'b0;
        end else begin
            take_o     <= 1'b1;
            vec_o      <= vec_d;
            cls_o      <= cls_d;
            ext_o      <= nmi_take_d | intr_take_d;
            ret_pc_o   <= use_next_d ? next_pc_i : cur_pc_i;
            restart_o  <= (cls_d != CLS_ABORT);
            intr_ack_o <= intr_take_d;
        end
    end
endmodule

// File: rtl/evt_arb_chk.sv
// Assertion checker for evt_accept_arb, attached by bind below.
// Assumes the same parameters as the top it watches.
module evt_arb_chk #(
    parameter int NEXC = 32,
    parameter int AW   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary_i,
    input logic              if_en_i,
    input logic              swi_req_i,
    input logic [2*NEXC-1:0] exc_kind_i,
    input logic [AW-1:0]     cur_pc_i,
    input logic              take_o,
    input logic [7:0]        vec_o,
    input logic [2:0]        cls_o,
    input logic              ext_o,
    input logic [AW-1:0]     ret_pc_o,
    input logic              restart_o
    ,input logic             intr_ack_o
);
    a_r2_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i));
    a_r2_quiet_without_take: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cls_o == 3'd0 && !ext_o && !intr_ack_o));
    a_r5_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cls_o == 3'd5) |-> (vec_o == 8'd2));
    a_r6_masked_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cls_o == 3'd6) |-> $past(if_en_i));
    a_r7_ack_matches_class: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack_o |-> (take_o && cls_o == 3'd6));
    a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack_o |=> !intr_ack_o || $past(boundary_i));
    a_r3_exceptions_beat_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ext_o) |-> ($past(exc_kind_i) == '0 && !$past(swi_req_i)));
    a_r9_fault_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cls_o == 3'd2) |-> (ret_pc_o == $past(cur_pc_i)));
    a_r10_abort_not_restartable: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cls_o == 3'd1) |-> !restart_o);
    a_r11_ext_pins_only: assert property (@(posedge clk) disable iff (!rst_n)
        ext_o |-> (cls_o == 3'd5 || cls_o == 3'd6));
endmodule

bind evt_accept_arb evt_arb_chk #(.NEXC(NEXC), .AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .if_en_i    (if_en_i),
    .swi_req_i  (swi_req_i),
    .exc_kind_i (exc_kind_i),
    .cur_pc_i   (cur_pc_i),
    .take_o     (take_o),
    .vec_o      (vec_o),
    .cls_o      (cls_o),
    .ext_o      (ext_o),
    .ret_pc_o   (ret_pc_o),
    .restart_o  (restart_o),
    .intr_ack_o (intr_ack_o)
);

// File: tb/evt_accept_arb_tb_top.sv
`timescale 1ns/1ps
module evt_accept_arb_tb_top;
    localparam int NEXC = 32;
    localparam int AW   = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              boundary_i, if_en_i, nmi_i, intr_i, swi_req_i;
    logic [7:0]        intr_vec_i, swi_vec_i;
    logic [2*NEXC-1:0] exc_kind_i;
    logic [AW-1:0]     cur_pc_i, next_pc_i;
    logic              take_o, ext_o, restart_o, intr_ack_o;
    logic [7:0]        vec_o;
    logic [2:0]        cls_o;
    logic [AW-1:0]     ret_pc_o;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state derived from the requirements.
    logic       m_nmi_pend, m_nmi_prev, m_intr_pend;
    logic [7:0] m_intr_vec;
    logic       e_take, e_ext, e_restart, e_ack;
    logic [7:0] e_vec;
    logic [2:0] e_cls;
    logic [AW-1:0] e_ret;

    always #2.5 clk = ~clk;

    evt_accept_arb #(.NEXC(NEXC), .AW(AW)) dut_i (.*);

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Predict the decision for the inputs now driven, update the model,
    // let one clock edge pass and compare at the following falling edge.
    task automatic step();
        int lo_a = -1, lo_f = -1, lo_t = -1;
        logic use_next = 1'b0;
        for (int i = NEXC - 1; i >= 0; i--) begin
            case (exc_kind_i[2*i +: 2])  // R4 kind encoding
                2'd3: lo_a = i;
                2'd1: lo_f = i;
                2'd2: lo_t = i;
                default: ;
            endcase
        end
        e_take = boundary_i; e_vec = 8'd0; e_cls = 3'd0; e_ext = 1'b0; e_ack = 1'b0;
        if (boundary_i) begin
            if (lo_a >= 0)      begin e_cls = 3'd1; e_vec = 8'(lo_a); end
            else if (lo_f >= 0) begin e_cls = 3'd2; e_vec = 8'(lo_f); end
            else if (lo_t >= 0) begin e_cls = 3'd3; e_vec = 8'(lo_t); use_next = 1'b1; end
            else if (swi_req_i) begin e_cls = 3'd4; e_vec = swi_vec_i; use_next = 1'b1; end
            else if (m_nmi_pend) begin e_cls = 3'd5; e_vec = 8'd2; use_next = 1'b1; e_ext = 1'b1; end
            else if (m_intr_pend && if_en_i) begin
                e_cls = 3'd6; e_vec = m_intr_vec; use_next = 1'b1; e_ext = 1'b1; e_ack = 1'b1;
            end else e_take = 1'b0;
        end
        e_restart = e_take && (e_cls != 3'd1);
        e_ret = !e_take ? '0 : (use_next ? next_pc_i : cur_pc_i);
        m_nmi_pend = (m_nmi_pend && e_cls != 3'd5) || (nmi_i && !m_nmi_prev);
        m_nmi_prev = nmi_i;
        if (e_cls == 3'd6) m_intr_pend = 1'b0;
        else if (!m_intr_pend && intr_i) begin m_intr_pend = 1'b1; m_intr_vec = intr_vec_i; end
        @(negedge clk);
        cmp("R2 take",       take_o,     e_take);
        cmp("R3 vector",     vec_o,      e_vec);
        cmp("R12 class",     cls_o,      e_cls);
        cmp("R11 external",  ext_o,      e_ext);
        cmp("R9 return ptr", ret_pc_o,   e_ret);
        cmp("R10 restart",   restart_o,  e_restart);
        cmp("R7 ack",        intr_ack_o, e_ack);
    endtask

    task automatic idle();
        boundary_i = 0; swi_req_i = 0; exc_kind_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; if_en_i = 0; nmi_i = 0; intr_i = 0; intr_vec_i = 0; swi_vec_i = 0;
        cur_pc_i = 32'h1000; next_pc_i = 32'h1004; idle();
        m_nmi_pend = 0; m_nmi_prev = 0; m_intr_pend = 0; m_intr_vec = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cmp("R1 take", take_o, 0);
        cmp("R1 class", cls_o, 0);
        cmp("R1 ack", intr_ack_o, 0);
        boundary_i = 1; if_en_i = 1; step();   // R1 nothing pending
        // R5 NMI taken with interrupts masked, vector 2
        if_en_i = 0; nmi_i = 1; boundary_i = 0; step();
        nmi_i = 0; boundary_i = 1; step();
        step();                                 // R5 cleared once taken
        // R6 masked request held pending, then accepted with ack (R7)
        intr_i = 1; intr_vec_i = 8'h41; boundary_i = 0; step();
        intr_i = 0; intr_vec_i = 8'h99; boundary_i = 1; step(); step();
        if_en_i = 1; step(); step();
        // R3 R8 collision: abort, fault, trap with NMI pending; NMI survives
        nmi_i = 1; boundary_i = 0; step(); nmi_i = 0;
        boundary_i = 1; exc_kind_i = '0;
        exc_kind_i[2*9 +: 2] = 2'd3; exc_kind_i[2*4 +: 2] = 2'd3;
        exc_kind_i[2*1 +: 2] = 2'd1; exc_kind_i[2*3 +: 2] = 2'd2;
        swi_req_i = 1; swi_vec_i = 8'h80; step();
        idle(); boundary_i = 1; step();         // R8 NMI still pending, exceptions gone
        // R4 kind 0 ignored; trap returns next pointer (R9)
        exc_kind_i[2*0 +: 2] = 2'd0; exc_kind_i[2*7 +: 2] = 2'd2; next_pc_i = 32'h2000; step();
        // R8 exceptions outside a boundary are discarded
        idle(); exc_kind_i[2*13 +: 2] = 2'd1; step(); idle(); boundary_i = 1; step();
        // Random mix
        for (int c = 0; c < 3000; c++) begin
            idle();
            boundary_i = ($urandom_range(0, 1) == 1);
            if_en_i    = ($urandom_range(0, 9) < 7);
            if ($urandom_range(0, 9) == 0) nmi_i = ~nmi_i;
            intr_i     = ($urandom_range(0, 3) == 0);
            intr_vec_i = 8'($urandom_range(32, 255));
            swi_req_i  = ($urandom_range(0, 7) == 0);
            swi_vec_i  = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 3) == 0)
                for (int j = 0; j < 3; j++)
                    exc_kind_i[2*$urandom_range(0, NEXC-1) +: 2] = 2'($urandom_range(0, 3));
            cur_pc_i  = $urandom;
            next_pc_i = $urandom;
            step();
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule